// File: doc/BRIEF.md
# Mode Register Capture and Burst Column Sequencer

This block sits on the command side of a double-data-rate memory interface. It watches the command bus for register-write commands and keeps two configuration registers. The mode register holds burst length, burst ordering and read latency. The extended register holds the delay-locked-loop enable and the output drive strength. Every write is checked for legality. An illegal write is refused, raises a one-cycle error flag and leaves the old settings in place.

When `burst_start` is pulsed, the block takes the start column from the low address bits. It then emits one column address per clock cycle for the whole burst, ordered either sequentially or interleaved as configured. It flags the final beat. The burst uses a copy of the length and ordering taken at its start. A new burst may begin on the final beat of the previous one, so bursts can run back to back with no gap.

Top module: `mrs_burst_agen`

## Requirements
- R1: After synchronous active-low reset: burst length 2, sequential order, read latency 3, DLL enabled, drive strength 00, `beat_valid` low, `cfg_err` low.
- R2: A register write is recognised only when `cs_n`, `ras_n`, `cas_n` and `we_n` are all low at a rising edge. With `cs_n` high, or with any one strobe high, the settings do not change.
- R3: With `ba[0]`=0 the write goes to the mode register, and the new settings show in the cycle after the edge. Burst length code `addr[2:0]`: 001 gives 2, 010 gives 4, 011 gives 8, 111 gives full page (2^COL_W). `addr[3]`: 0 selects sequential, 1 selects interleave. Latency code `addr[6:4]`: 011 gives 3, 100 gives 4.
- R4: A mode write is refused in any of these cases: a reserved length code, a reserved latency code, any of `addr[11:7]` set, `ba[1]` set, or full page combined with interleave. A refused write sets `cfg_err` for exactly one cycle and keeps every setting.
- R5: With `ba[0]`=1 the write goes to the extended register: `dll_en` becomes the inverse of `addr[0]` and `drive_str` becomes {`addr[6]`,`addr[1]`}. Mode fields are untouched. Any other address bit set, or `ba[1]` set, refuses the write as in R4.
- R6: A `burst_start` sampled at an edge takes `addr[COL_W-1:0]` as the start column. From the next cycle, `beat_valid` is high for exactly BL consecutive cycles with one column per cycle, and `burst_done` is high only on the last of those cycles.
- R7: In sequential order, beat i is the aligned BL-sized block base of the start column, OR'd with ((start + i) mod BL).
- R8: In interleave order, beat i is the start column XOR i.
- R9: A full-page burst produces 2^COL_W beats with column (start + i) mod 2^COL_W. An odd start column is refused: `cfg_err` is set for one cycle and no beat is produced.
- R10: `burst_start` is ignored while a burst is running, except on its final beat, where the new burst's first beat follows in the very next cycle.
- R11: Length and order are fixed when a burst starts. A mode write during the burst changes the outputs but not the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, low enables command decode |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write enable strobe |
| ba | input | 2 | Bank bits; bit 0 picks the register |
| addr | input | ADDR_W | Address bus: register contents or start column |
| burst_start | input | 1 | Begin a burst at column addr[COL_W-1:0] |
| cas_lat | output | 3 | Read latency in cycles (3 or 4) |
| burst_len | output | COL_W+1 | Burst length in beats |
| burst_ilv | output | 1 | 1 = interleave order |
| dll_en | output | 1 | DLL enable |
| drive_str | output | 2 | Drive strength {addr[6],addr[1]} |
| col_addr | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | A burst beat is present |
| burst_done | output | 1 | Current beat is the last |
| cfg_err | output | 1 | Refused write or refused burst, one cycle |

## Verification
The bench builds the block with its defaults, ADDR_W = 12 and COL_W = 8. This makes the full-page burst 256 beats long, so the bench can follow it completely, including the wrap from column 255 back to 0. The 8-bit column lets short bursts start at mid-block offsets such as 0x3D, so block-base preservation and the XOR ordering are both exercised away from column zero. The 12-bit bus keeps `addr[11:7]` available for the reserved-bit refusals.

// File: rtl/mrs_agen_pkg.sv
// Package: shared configuration types and field decode helpers for the
// mode register capture and burst column sequencer.
package mrs_agen_pkg;

    // Register-write command class produced by the command decoder.
    typedef enum logic [1:0] {
        RCMD_NONE = 2'd0,
        RCMD_MODE = 2'd1,
        RCMD_EXT  = 2'd2
    } reg_cmd_e;

    // Current configuration as held by the register file.
    typedef struct packed {
        logic [3:0] len_log2;
        logic       ilv;
        logic [2:0] cas_lat;
        logic       dll_en;
        logic [1:0] drive;
    } mode_cfg_t;

    // True for the burst length codes that are defined.
    function automatic logic bl_code_ok(input logic [2:0] code);
        return (code == 3'b001) || (code == 3'b010) ||
               (code == 3'b011) || (code == 3'b111);
    endfunction

    // True for the read latency codes that are defined.
    function automatic logic cl_code_ok(input logic [2:0] code);
        return (code == 3'b011) || (code == 3'b100);
    endfunction

    // log2 of the burst length for a defined code; full page maps to col_w.
    function automatic logic [3:0] bl_log2(input logic [2:0] code,
                                           input int unsigned col_w);
        logic [3:0] r;
        case (code)
            3'b001:  r = 4'd1;
            3'b010:  r = 4'd2;
            3'b011:  r = 4'd3;
            default: r = 4'(col_w);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mrs_cmd_decode.sv
// Module: mrs_cmd_decode
// Classifies the command bus into "mode register write", "extended
// register write" or nothing. Purely combinational.
// Assumes: strobes are active low and sampled by the caller on the
// rising edge; cs_n high masks every command.
module mrs_cmd_decode
    import mrs_agen_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    input  logic     ba0,
    output reg_cmd_e cmd
);

    logic is_reg_wr;

    // Register write needs every strobe low together with chip select.
    always_comb begin
        is_reg_wr = !cs_n && !ras_n && !cas_n && !we_n;
        if (!is_reg_wr)
            cmd = RCMD_NONE;
        else if (ba0)
            cmd = RCMD_EXT;
        else
            cmd = RCMD_MODE;
    end

endmodule

// File: rtl/mrs_cfg_regs.sv
// Module: mrs_cfg_regs
// Holds the mode and extended register settings, validates every write,
// and refuses illegal ones with a one-cycle error pulse while keeping the
// previous contents.
// Assumes: ADDR_W >= 12 so that the fixed field positions exist; COL_W
// below 16 so that the full-page log2 fits in four bits.
module mrs_cfg_regs
    import mrs_agen_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_cmd_e          cmd,
    input  logic              ba1,
    input  logic [ADDR_W-1:0] addr,
    output mode_cfg_t         cfg,
    output logic              err
);

    localparam logic [3:0] FULL_LOG2 = 4'(COL_W);

    mode_cfg_t   cfg_nxt;
    logic        mode_ok;
    logic        ext_ok;
    logic        upper_zero;
    logic [ADDR_W-1:0] ext_keep_mask;

    // Build the mask of address bits that the extended register may use.
    always_comb begin
        ext_keep_mask    = '0;
        ext_keep_mask[0] = 1'b1;
        ext_keep_mask[1] = 1'b1;
        ext_keep_mask[6] = 1'b1;
    end

    // Legality checks for both register kinds.
    always_comb begin
        upper_zero = (addr[ADDR_W-1:7] == '0);
        mode_ok    = bl_code_ok(addr[2:0]) && cl_code_ok(addr[6:4]) &&
                     upper_zero && !ba1 &&
                     !((addr[2:0] == 3'b111) && addr[3]);
        ext_ok     = ((addr & ~ext_keep_mask) == '0) && !ba1;
    end

    // Next settings when the current write is accepted.
    always_comb begin
        cfg_nxt = cfg;
        if (cmd == RCMD_MODE && mode_ok) begin
            cfg_nxt.len_log2 = bl_log2(addr[2:0], COL_W);
            cfg_nxt.ilv      = addr[3];
            cfg_nxt.cas_lat  = addr[6:4];
        end else if (cmd == RCMD_EXT && ext_ok) begin
            cfg_nxt.dll_en = !addr[0];
            cfg_nxt.drive  = {addr[6], addr[1]};
        end
    end

    // Store accepted settings and pulse the error on a refused write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.len_log2 <= 4'd1;
            cfg.ilv      <= 1'b0;
            cfg.cas_lat  <= 3'd3;
            cfg.dll_en   <= 1'b1;
            cfg.drive    <= 2'b00;
            err          <= 1'b0;
        end else begin
            cfg <= cfg_nxt;
            err <= ((cmd == RCMD_MODE) && !mode_ok) ||
                   ((cmd == RCMD_EXT)  && !ext_ok);
        end
    end

    // Full page is encoded as log2 equal to the column width.
    logic unused_full;
    assign unused_full = (cfg.len_log2 == FULL_LOG2);

endmodule

// File: rtl/burst_col_gen.sv
// Module: burst_col_gen
// Produces one column address per cycle for a burst, in sequential
// (wrap within the aligned block) or interleave (start XOR beat) order.
// Length and order are captured at burst start. A new start is taken
// when idle or on the final beat; a full-page start on an odd column is
// refused with a one-cycle error.
// Assumes: full page is never combined with interleave (the register
// file refuses that setting).
module burst_col_gen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [3:0]       len_log2,
    input  logic             ilv,
    output logic [COL_W-1:0] col,
    output logic             valid,
    output logic             done,
    output logic             err
);

    logic             active_q;
    logic [COL_W-1:0] cnt_q;
    logic [COL_W-1:0] start_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;

    logic [COL_W:0]   one_sh;
    logic [COL_W-1:0] mask_n;
    logic             full_pg_n;
    logic             last;
    logic             take;
    logic             refuse;
    logic [COL_W-1:0] offset;

    // Mask of the in-block offset bits for the requested length.
    always_comb begin
        one_sh    = (COL_W+1)'(1) << len_log2;
        mask_n    = COL_W'(one_sh - (COL_W+1)'(1));
        full_pg_n = (len_log2 == 4'(COL_W));
    end

    // Start acceptance: idle or last beat; odd full-page start refused.
    always_comb begin
        last   = active_q && (cnt_q == mask_q);
        take   = start && (!active_q || last);
        refuse = take && full_pg_n && start_col[0];
    end

    // Burst state: beat counter and captured parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            start_q  <= '0;
            mask_q   <= '0;
            ilv_q    <= 1'b0;
            err      <= 1'b0;
        end else begin
            err <= refuse;
            if (take && !refuse) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
                start_q  <= start_col;
                mask_q   <= mask_n;
                ilv_q    <= ilv;
            end else if (active_q) begin
                if (last)
                    active_q <= 1'b0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Column of the current beat from the captured start and counter.
    always_comb begin
        if (ilv_q)
            offset = (start_q ^ cnt_q) & mask_q;
        else
            offset = (start_q + cnt_q) & mask_q;
        col   = (start_q & ~mask_q) | offset;
        valid = active_q;
        done  = last;
    end

endmodule

// File: rtl/mrs_burst_agen.sv
// Module: mrs_burst_agen (top)
// Captures mode / extended register writes from the command bus and
// sequences burst column addresses according to the stored settings.
// Assumes: synchronous active-low reset; one clock domain.
module mrs_burst_agen
    import mrs_agen_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [1:0]        ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst_start,
    output logic [2:0]        cas_lat,
    output logic [COL_W:0]    burst_len,
    output logic              burst_ilv,
    output logic              dll_en,
    output logic [1:0]        drive_str,
    output logic [COL_W-1:0]  col_addr,
    output logic              beat_valid,
    output logic              burst_done,
    output logic              cfg_err
);

    reg_cmd_e  cmd;
    mode_cfg_t cfg;
    logic      reg_err;
    logic      burst_err;

    mrs_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba0   (ba[0]),
        .cmd   (cmd)
    );

    mrs_cfg_regs #(
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .ba1   (ba[1]),
        .addr  (addr),
        .cfg   (cfg),
        .err   (reg_err)
    );

    burst_col_gen #(
        .COL_W (COL_W)
    ) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (burst_start),
        .start_col (addr[COL_W-1:0]),
        .len_log2  (cfg.len_log2),
        .ilv       (cfg.ilv),
        .col       (col_addr),
        .valid     (beat_valid),
        .done      (burst_done),
        .err       (burst_err)
    );

    // Present the stored settings in decoded form.
    always_comb begin
        cas_lat   = cfg.cas_lat;
        burst_len = (COL_W+1)'(1) << cfg.len_log2;
        burst_ilv = cfg.ilv;
        dll_en    = cfg.dll_en;
        drive_str = cfg.drive;
        cfg_err   = reg_err || burst_err;
    end

endmodule

// File: rtl/mrs_agen_checker.sv
// Module: mrs_agen_checker
// Temporal properties of mrs_burst_agen, attached by bind.
module mrs_agen_checker #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic [2:0]       cas_lat,
    input logic [COL_W:0]   burst_len,
    input logic             burst_ilv,
    input logic             dll_en,
    input logic [1:0]       drive_str,
    input logic             beat_valid,
    input logic             burst_done,
    input logic             reg_err
);

    localparam logic [COL_W:0] FULL_LEN = (COL_W+1)'(1) << COL_W;

    logic [COL_W+8:0] settings;
    assign settings = {cas_lat, burst_len, burst_ilv, dll_en, drive_str};

    a_r2_cs_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(settings));

    a_r3_latency_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_lat == 3'd3) || (cas_lat == 3'd4));

    a_r4_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> $stable(settings));

    a_r4_fullpage_seq_only: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_len == FULL_LEN) |-> !burst_ilv);

    a_r6_done_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> beat_valid);

    a_r6_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !burst_done) |=> beat_valid);

endmodule

bind mrs_burst_agen mrs_agen_checker #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .cas_lat    (cas_lat),
    .burst_len  (burst_len),
    .burst_ilv  (burst_ilv),
    .dll_en     (dll_en),
    .drive_str  (drive_str),
    .beat_valid (beat_valid),
    .burst_done (burst_done),
    .reg_err    (reg_err)
);

// File: tb/mrs_burst_agen_tb.sv
// Directed bench for mrs_burst_agen: one task per scenario.
module mrs_burst_agen_tb;

    localparam int ADDR_W = 12;
    localparam int COL_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]        ba = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic              burst_start = 1'b0;
    logic [2:0]        cas_lat;
    logic [COL_W:0]    burst_len;
    logic              burst_ilv, dll_en, beat_valid, burst_done, cfg_err;
    logic [1:0]        drive_str;
    logic [COL_W-1:0]  col_addr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mrs_burst_agen #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .burst_start(burst_start),
        .cas_lat(cas_lat), .burst_len(burst_len), .burst_ilv(burst_ilv),
        .dll_en(dll_en), .drive_str(drive_str), .col_addr(col_addr),
        .beat_valid(beat_valid), .burst_done(burst_done), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mword(input logic [2:0] bl, input logic il,
                                          input logic [2:0] cl);
        return {5'b0, cl, il, bl};
    endfunction

    function automatic int exp_col(input int start, input int i, input int len,
                                   input bit il);
        int m;
        m = len - 1;
        if (il) return (start ^ i) & 255;
        return (start & ~m & 255) | ((start + i) & m);
    endfunction

    // Issue one command cycle; returns at the next falling edge.
    task automatic cmd_cycle(input logic c, input logic r, input logic ca,
                             input logic w, input logic [1:0] b,
                             input logic [11:0] a);
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
        @(negedge clk);
        cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; addr = 0;
    endtask

    task automatic reg_write(input logic [1:0] b, input logic [11:0] a);
        cmd_cycle(0, 0, 0, 0, b, a);
    endtask

    task automatic check_cfg(input string req, input int len, input bit il,
                             input int cl, input bit dll, input int drv,
                             input bit err);
        chk(burst_len == len, {req, " len"}, int'(burst_len), len);
        chk(burst_ilv == il, {req, " order"}, int'(burst_ilv), int'(il));
        chk(cas_lat == cl, {req, " latency"}, int'(cas_lat), cl);
        chk(dll_en == dll, {req, " dll"}, int'(dll_en), int'(dll));
        chk(drive_str == drv, {req, " drive"}, int'(drive_str), drv);
        chk(cfg_err == err, {req, " cfg_err"}, int'(cfg_err), int'(err));
    endtask

    // Run one burst and check every beat.
    task automatic run_burst(input string req, input int start, input int len,
                             input bit il);
        @(negedge clk);
        burst_start = 1; addr = 12'(start);
        @(negedge clk);
        burst_start = 0; addr = 0;
        for (int i = 0; i < len; i++) begin
            chk(beat_valid == 1, {req, " valid"}, int'(beat_valid), 1);
            chk(col_addr == exp_col(start, i, len, il), {req, " column"},
                int'(col_addr), exp_col(start, i, len, il));
            chk(burst_done == (i == len - 1), {req, " done"}, int'(burst_done),
                int'(i == len - 1));
            @(negedge clk);
        end
        chk(beat_valid == 0, {req, " end"}, int'(beat_valid), 0);
    endtask

    task automatic t_reset();
        check_cfg("R1 reset", 2, 0, 3, 1, 0, 0);
        chk(beat_valid == 0, "R1 reset valid", int'(beat_valid), 0);
    endtask

    task automatic t_mode();
        reg_write(2'b00, mword(3'b010, 0, 3'b100));
        check_cfg("R3 bl4 seq cl4", 4, 0, 4, 1, 0, 0);
        reg_write(2'b00, mword(3'b011, 1, 3'b011));
        check_cfg("R3 bl8 ilv cl3", 8, 1, 3, 1, 0, 0);
        reg_write(2'b00, mword(3'b111, 0, 3'b011));
        check_cfg("R3 full seq", 256, 0, 3, 1, 0, 0);
        reg_write(2'b00, mword(3'b001, 0, 3'b100));
        check_cfg("R3 bl2", 2, 0, 4, 1, 0, 0);
    endtask

    task automatic t_reserved();
        logic [11:0] bad [8];
        logic [1:0]  bb  [8];
        reg_write(2'b00, mword(3'b010, 0, 3'b100));
        bad[0] = mword(3'b000, 0, 3'b011); bb[0] = 2'b00;
        bad[1] = mword(3'b101, 0, 3'b011); bb[1] = 2'b00;
        bad[2] = mword(3'b011, 0, 3'b010); bb[2] = 2'b00;
        bad[3] = mword(3'b011, 0, 3'b011) | 12'h080; bb[3] = 2'b00;
        bad[4] = mword(3'b011, 0, 3'b011) | 12'h100; bb[4] = 2'b00;
        bad[5] = mword(3'b011, 0, 3'b011); bb[5] = 2'b10;
        bad[6] = mword(3'b111, 1, 3'b011); bb[6] = 2'b00;
        bad[7] = mword(3'b011, 0, 3'b011) | 12'h800; bb[7] = 2'b00;
        for (int k = 0; k < 8; k++) begin
            reg_write(bb[k], bad[k]);
            check_cfg($sformatf("R4 refuse %0d", k), 4, 0, 4, 1, 0, 1);
            @(negedge clk);
            chk(cfg_err == 0, "R4 pulse one cycle", int'(cfg_err), 0);
        end
    endtask

    task automatic t_ext();
        reg_write(2'b01, 12'h001);
        check_cfg("R5 dll off", 4, 0, 4, 0, 0, 0);
        reg_write(2'b01, 12'h042);
        check_cfg("R5 drive 11", 4, 0, 4, 1, 3, 0);
        reg_write(2'b01, 12'h040);
        check_cfg("R5 drive 10", 4, 0, 4, 1, 2, 0);
        reg_write(2'b01, 12'h004);
        check_cfg("R5 refuse bit2", 4, 0, 4, 1, 2, 1);
        reg_write(2'b11, 12'h000);
        check_cfg("R5 refuse ba1", 4, 0, 4, 1, 2, 1);
    endtask

    task automatic t_cs();
        cmd_cycle(1, 0, 0, 0, 2'b00, mword(3'b011, 1, 3'b011));
        check_cfg("R2 cs high", 4, 0, 4, 1, 2, 0);
        cmd_cycle(0, 0, 0, 1, 2'b00, mword(3'b011, 1, 3'b011));
        check_cfg("R2 we high", 4, 0, 4, 1, 2, 0);
        cmd_cycle(0, 1, 0, 0, 2'b01, 12'h001);
        check_cfg("R2 ras high", 4, 0, 4, 1, 2, 0);
    endtask

    task automatic t_seq();
        reg_write(2'b00, mword(3'b010, 0, 3'b011));
        run_burst("R7 seq bl4", 8'h12, 4, 0);
        reg_write(2'b00, mword(3'b011, 0, 3'b011));
        run_burst("R7 seq bl8", 8'h3D, 8, 0);
        reg_write(2'b00, mword(3'b001, 0, 3'b011));
        run_burst("R6 seq bl2", 8'h07, 2, 0);
    endtask

    task automatic t_ilv();
        reg_write(2'b00, mword(3'b011, 1, 3'b011));
        run_burst("R8 ilv bl8", 8'h3D, 8, 1);
        reg_write(2'b00, mword(3'b010, 1, 3'b011));
        run_burst("R8 ilv bl4", 8'h12, 4, 1);
    endtask

    task automatic t_full();
        reg_write(2'b00, mword(3'b111, 0, 3'b011));
        run_burst("R9 full page", 8'hFE, 256, 0);
        @(negedge clk);
        burst_start = 1; addr = 12'h007;
        @(negedge clk);
        burst_start = 0; addr = 0;
        chk(cfg_err == 1, "R9 odd start err", int'(cfg_err), 1);
        chk(beat_valid == 0, "R9 odd start no beat", int'(beat_valid), 0);
        @(negedge clk);
        chk(beat_valid == 0, "R9 odd start stays idle", int'(beat_valid), 0);
    endtask

    task automatic t_busy();
        int exp1 [4] = '{8'h12, 8'h13, 8'h10, 8'h11};
        int exp2 [4] = '{8'h25, 8'h26, 8'h27, 8'h24};
        reg_write(2'b00, mword(3'b010, 0, 3'b011));
        @(negedge clk);
        burst_start = 1; addr = 12'h012;
        @(negedge clk);
        burst_start = 0; addr = 0;
        for (int i = 0; i < 4; i++) begin
            chk(col_addr == exp1[i], "R10 first burst", int'(col_addr), exp1[i]);
            chk(burst_done == (i == 3), "R10 first done", int'(burst_done), int'(i == 3));
            if (i == 0 || i == 3) begin
                burst_start = 1;
                addr = (i == 0) ? 12'h040 : 12'h025;
            end
            @(negedge clk);
            burst_start = 0; addr = 0;
        end
        for (int i = 0; i < 4; i++) begin
            chk(beat_valid == 1, "R10 chained valid", int'(beat_valid), 1);
            chk(col_addr == exp2[i], "R10 chained burst", int'(col_addr), exp2[i]);
            @(negedge clk);
        end
        chk(beat_valid == 0, "R10 chained end", int'(beat_valid), 0);
    endtask

    task automatic t_latched();
        reg_write(2'b00, mword(3'b010, 0, 3'b011));
        @(negedge clk);
        burst_start = 1; addr = 12'h000;
        @(negedge clk);
        burst_start = 0; addr = 0;
        chk(col_addr == 0, "R11 beat0", int'(col_addr), 0);
        cs_n = 0; ras_n = 0; cas_n = 0; we_n = 0; addr = mword(3'b011, 1, 3'b011);
        @(negedge clk);
        cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; addr = 0;
        chk(burst_len == 8, "R11 new setting visible", int'(burst_len), 8);
        for (int i = 1; i < 4; i++) begin
            chk(col_addr == i, "R11 kept order", int'(col_addr), i);
            chk(burst_done == (i == 3), "R11 kept length", int'(burst_done), int'(i == 3));
            @(negedge clk);
        end
        chk(beat_valid == 0, "R11 ends at old length", int'(beat_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_mode();
        t_reserved();
        t_ext();
        t_cs();
        t_seq();
        t_ilv();
        t_full();
        t_busy();
        t_latched();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule